// File: doc/BRIEF.md
# Asynchronous Bus Cycle Error Terminator

This block steps one processor-side asynchronous bus cycle through its numbered half-clock states and decides how the cycle ends. A request on `start` picks the cycle kind: read, write or read-modify-write. The block drives the address strobe. At the sampling state it looks at the slave's acknowledge, the external bus error line and the halt line. From these it chooses one of three endings: a normal end, an error end with acknowledge present, or an error end on bus error alone. The ending state number depends on which of these occurs and on which half of a read-modify-write cycle is running.

A watchdog counts clocks while the address strobe is asserted. When the count reaches a programmable limit, it raises an internal bus error. This gives each slave its own maximum response time without any external delay logic. Each simulation clock stands for one state, so the state number advances by one per clock.

Top module: `bus_err_term`

## Requirements
- R1: A synchronous active-high `rst` returns the block to idle. In idle `as_o` is 0, `st_num` is 0, both done outputs are 0 and the watchdog count is 0.
- R2: When `start` is high in idle, `st_num` is 0 on the next clock and then rises by one per clock. `as_o` is 1 from state 2 through the ending state, and 0 on the clock after it.
- R3: Responses are sampled in state 4, or in state 16 for the write half of a read-modify-write cycle. If no response is present, the state number holds for one clock (a wait state) and the lines are sampled again.
- R4: Acknowledge without a recognised bus error ends the cycle normally in state 7, or in state 19 for the write half. `done_ok` is high for exactly that one clock.
- R5: Acknowledge together with a recognised bus error ends the cycle in state 7, or in state 19 for the write half. `done_err` is high for that one clock.
- R6: A recognised bus error without acknowledge ends the cycle in state 9, or in state 21 for the write half. `done_err` is high for that one clock.
- R7: A bus error is recognised only while `halt` is 0. An acknowledge sampled before the bus error arrives decides the cycle as normal, and a later bus error has no effect.
- R8: `cyc_kind` encoding: 0 is read, 1 and 3 are write, 2 is read-modify-write. In a read-modify-write cycle, a normal read half continues at state 8 with `as_o` held high, and only the write half asserts `done_ok`. A read half that ends in error finishes the whole cycle.
- R9: The watchdog counts clocks with `as_o` high, starting from 0 in state 2. A nonzero `wd_limit` raises an internal bus error once the count reaches the limit, and a limit of 0 turns the watchdog off. The count is cleared while `as_o` is 0 and restarts from 0 at state 8.
- R10: `start` is ignored while a cycle is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one state per edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a cycle (idle only) |
| cyc_kind | input | 2 | 0 read, 1/3 write, 2 read-modify-write |
| ack | input | 1 | Slave data acknowledge, active high |
| berr | input | 1 | External bus error, active high |
| halt | input | 1 | Halt line, active high; masks bus error |
| wd_limit | input | WD_W | Watchdog limit in clocks after strobe; 0 disables |
| as_o | output | 1 | Address strobe, active high |
| st_num | output | 5 | Current state number |
| done_ok | output | 1 | One-clock pulse on a normal end |
| done_err | output | 1 | One-clock pulse on a bus-error end |

## Verification
The assertions assume that `ack`, `berr` and `halt` are synchronous to `clk` and stable around the sampling edge. They also assume that `rst` is applied at the start. The stimulus changes every input on the falling edge only. It raises responses only when the visible state number shows the sampling state. It holds each response until the state has moved on, and then drops it. Tests that supply explicit responses either turn the watchdog off or set its limit beyond the wait states used, so an unintended internal bus error cannot mix with the chosen response.

// File: rtl/bet_pkg.sv
package bet_pkg;
  localparam int ST_W = 5;
  localparam logic [ST_W-1:0] ST_AS_ON    = 5'd2;
  localparam logic [ST_W-1:0] ST_WR_FIRST = 5'd8;
  localparam logic [ST_W-1:0] ST_RD_SAMP  = 5'd4;
  localparam logic [ST_W-1:0] ST_WR_SAMP  = 5'd16;
  localparam logic [1:0]      KIND_RMW    = 2'd2;

  typedef enum logic [1:0] {
    END_NORM  = 2'd0,
    END_BOTH  = 2'd1,
    END_ALONE = 2'd2
  } end_e;

  // state where responses are sampled, per half
  function automatic logic [ST_W-1:0] sample_st(input logic wr_half);
    return wr_half ? ST_WR_SAMP : ST_RD_SAMP;
  endfunction

  // ending state: three states after sampling, five on lone bus error
  function automatic logic [ST_W-1:0] end_st(input logic wr_half, input end_e k);
    return sample_st(wr_half) + ((k == END_ALONE) ? 5'd5 : 5'd3);
  endfunction
endpackage

// File: rtl/bet_watchdog.sv
module bet_watchdog #(
  parameter int WD_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            as_on,
  input  logic            restart,
  input  logic [WD_W-1:0] limit,
  output logic            fire
);
  localparam logic [WD_W-1:0] CNT_MAX = {WD_W{1'b1}};
  logic [WD_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !as_on || restart) cnt <= '0;
    else if (cnt != CNT_MAX)      cnt <= cnt + 1'b1;
  end

  assign fire = (limit != '0) && as_on && (cnt >= limit);
endmodule

// File: rtl/bet_decide.sv
module bet_decide (
  input  logic ack,
  input  logic berr_req,
  input  logic halt,
  output logic dec_norm,
  output logic dec_both,
  output logic dec_alone
);
  logic berr_rec;
  assign berr_rec  = berr_req && !halt;
  assign dec_norm  = ack && !berr_rec;
  assign dec_both  = ack && berr_rec;
  assign dec_alone = !ack && berr_rec;
endmodule

// File: rtl/bus_err_term.sv
module bus_err_term
  import bet_pkg::*;
#(
  parameter int WD_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [1:0]      cyc_kind,
  input  logic            ack,
  input  logic            berr,
  input  logic            halt,
  input  logic [WD_W-1:0] wd_limit,
  output logic            as_o,
  output logic [ST_W-1:0] st_num,
  output logic            done_ok,
  output logic            done_err
);
  logic            busy, wh, decided, rmw_q;
  logic [ST_W-1:0] st;
  end_e            kind_q;

  logic            wd_fire, at_sample, at_end, go_write, finish;
  logic            dec_norm, dec_both, dec_alone, dec_any;
  logic [ST_W-1:0] samp_pt, fin_pt;

  assign samp_pt   = sample_st(wh);
  assign fin_pt    = end_st(wh, kind_q);
  assign at_sample = busy && !decided && (st == samp_pt);
  assign at_end    = busy && decided && (st == fin_pt);
  assign go_write  = at_end && (kind_q == END_NORM) && rmw_q && !wh;
  assign finish    = at_end && !go_write;
  assign dec_any   = dec_norm || dec_both || dec_alone;

  bet_watchdog #(.WD_W(WD_W)) u_wd (
    .clk     (clk),
    .rst     (rst),
    .as_on   (as_o),
    .restart (go_write),
    .limit   (wd_limit),
    .fire    (wd_fire)
  );

  bet_decide u_dec (
    .ack       (ack),
    .berr_req  (berr || wd_fire),
    .halt      (halt),
    .dec_norm  (dec_norm),
    .dec_both  (dec_both),
    .dec_alone (dec_alone)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      st      <= '0;
      wh      <= 1'b0;
      decided <= 1'b0;
      rmw_q   <= 1'b0;
      kind_q  <= END_NORM;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        st      <= '0;
        wh      <= 1'b0;
        decided <= 1'b0;
        rmw_q   <= (cyc_kind == KIND_RMW);
      end
    end else if (go_write) begin
      st      <= ST_WR_FIRST;
      wh      <= 1'b1;
      decided <= 1'b0;
    end else if (finish) begin
      busy    <= 1'b0;
      st      <= '0;
      wh      <= 1'b0;
      decided <= 1'b0;
    end else if (at_sample) begin
      if (dec_any) begin
        decided <= 1'b1;
        kind_q  <= dec_both ? END_BOTH : (dec_alone ? END_ALONE : END_NORM);
        st      <= st + 1'b1;
      end
    end else begin
      st <= st + 1'b1;
    end
  end

  assign as_o     = busy && (st >= ST_AS_ON);
  assign st_num   = st;
  assign done_ok  = finish && (kind_q == END_NORM);
  assign done_err = finish && (kind_q != END_NORM);
endmodule

// File: rtl/bus_err_term_chk.sv
module bus_err_term_chk (
  input logic       clk,
  input logic       rst,
  input logic       halt,
  input logic       as_o,
  input logic [4:0] st_num,
  input logic       done_ok,
  input logic       done_err,
  input logic       at_sample,
  input logic       dec_any,
  input logic       dec_both,
  input logic       dec_alone,
  input logic       wd_fire
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (!as_o && st_num == 5'd0 && !done_ok && !done_err));

  // R2
  strobe_start_chk: assert property (@(posedge clk) disable iff (rst) $rose(as_o) |-> st_num == 5'd2);

  // R3
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst) (at_sample && !dec_any) |=> ($stable(st_num) && as_o));

  // R4
  ok_state_chk: assert property (@(posedge clk) disable iff (rst) done_ok |-> (st_num == 5'd7 || st_num == 5'd19));

  // R5 R6
  err_state_chk: assert property (@(posedge clk) disable iff (rst)
    done_err |-> (st_num == 5'd7 || st_num == 5'd9 || st_num == 5'd19 || st_num == 5'd21));

  // R4 R5 R6
  done_excl_chk: assert property (@(posedge clk) disable iff (rst) $onehot0({done_ok, done_err}));

  // R2
  strobe_drop_chk: assert property (@(posedge clk) disable iff (rst) (done_ok || done_err) |=> !as_o);

  // R7
  halt_mask_chk: assert property (@(posedge clk) disable iff (rst) (dec_both || dec_alone) |-> !halt);

  // R9
  wd_strobe_chk: assert property (@(posedge clk) disable iff (rst) wd_fire |-> as_o);
endmodule

bind bus_err_term bus_err_term_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .halt      (halt),
  .as_o      (as_o),
  .st_num    (st_num),
  .done_ok   (done_ok),
  .done_err  (done_err),
  .at_sample (at_sample),
  .dec_any   (dec_any),
  .dec_both  (dec_both),
  .dec_alone (dec_alone),
  .wd_fire   (wd_fire)
);

// File: tb/tb_bus_err_term.sv
module tb_bus_err_term;
  localparam int CLK_PERIOD = 10;
  localparam int WD_W = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic [1:0]      cyc_kind = 2'd0;
  logic            ack = 1'b0, berr = 1'b0, halt = 1'b0;
  logic [WD_W-1:0] wd_limit = '0;
  logic            as_o, done_ok, done_err;
  logic [4:0]      st_num;

  int n_chk = 0, n_bad = 0, cyc = 0, as_cnt = 0;

  typedef struct packed { logic err; logic [4:0] st; logic [7:0] asn; } exp_t;
  exp_t q[$];

  // response codes: 0 none (watchdog), 1 ack, 2 ack+berr, 3 berr alone,
  // 4 halt+berr then ack, 5 ack then late berr
  bus_err_term #(.WD_W(WD_W)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (as_o) as_cnt = as_cnt + 1;
      if (done_ok || done_err) begin
        if (q.size() == 0) begin
          check("R10 unexpected end", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check("R4/R5/R6 error flag", int'(done_err), int'(e.err));
          check("R3/R8 end state", int'(st_num), int'(e.st));
          check("R2/R9 strobe clocks", as_cnt, int'(e.asn));
        end
        as_cnt = 0;
      end
    end
  end

  function automatic int waits(input int resp, input int w, input int lim, input int base);
    if (resp != 0) return w;
    return (lim > base) ? lim - base : 0;
  endfunction

  function automatic bit is_norm(input int resp);
    return resp == 1 || resp == 4 || resp == 5;
  endfunction

  task automatic wait_state(input int n);
    while (int'(st_num) != n) @(negedge clk);
  endtask

  task automatic apply(input int resp, input int w);
    if (resp == 0) return;
    if (resp == 4) begin halt = 1'b1; berr = 1'b1; end
    repeat (w) @(negedge clk);
    case (resp)
      1, 4, 5: ack = 1'b1;
      2: begin ack = 1'b1; berr = 1'b1; end
      default: berr = 1'b1;
    endcase
    @(negedge clk);
    ack = 1'b0; halt = 1'b0; berr = (resp == 5);
    if (resp == 5) @(negedge clk);
    berr = 1'b0;
  endtask

  task automatic run(input logic [1:0] kind, input int lim, input int r_resp, input int r_w,
                     input int w_resp, input int w_w, input bit poke);
    exp_t e;
    int n;
    bit two = (kind == 2'd2) && is_norm(r_resp);
    n = 6 + waits(r_resp, r_w, lim, 2);
    if (!two) begin
      e.err = !is_norm(r_resp);
      e.st  = (r_resp == 0 || r_resp == 3) ? 5'd9 : 5'd7;
      n     = n + ((r_resp == 0 || r_resp == 3) ? 2 : 0);
    end else begin
      e.err = !is_norm(w_resp);
      e.st  = (w_resp == 0 || w_resp == 3) ? 5'd21 : 5'd19;
      n     = n + 12 + waits(w_resp, w_w, lim, 8) + ((w_resp == 0 || w_resp == 3) ? 2 : 0);
    end
    e.asn = n[7:0];
    q.push_back(e);
    wd_limit = lim[WD_W-1:0];
    start = 1'b1; cyc_kind = kind;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      wait_state(3);
      start = 1'b1; cyc_kind = 2'd0;
      @(negedge clk);
      start = 1'b0;
    end
    wait_state(4);
    apply(r_resp, r_w);
    if (two) begin
      wait_state(16);
      apply(w_resp, w_w);
    end
    while (!(done_ok || done_err)) @(negedge clk);
    @(negedge clk);
    check("R2 strobe low after end", int'(as_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 strobe", int'(as_o), 0);
    check("R1 state", int'(st_num), 0);
    check("R1 done", int'(done_ok | done_err), 0);
    rst = 1'b0;
    @(negedge clk);
    run(2'd0, 0, 1, 0, 0, 0, 0);  // R4 read, ack at once
    run(2'd1, 0, 1, 3, 0, 0, 0);  // R3 R4 write with waits
    run(2'd0, 0, 2, 1, 0, 0, 0);  // R5
    run(2'd1, 0, 3, 2, 0, 0, 0);  // R6
    run(2'd0, 0, 4, 2, 0, 0, 0);  // R7 halt masks bus error
    run(2'd0, 0, 5, 0, 0, 0, 0);  // R7 late bus error ignored
    run(2'd2, 0, 1, 0, 1, 2, 0);  // R8 rmw normal
    run(2'd2, 0, 1, 1, 2, 0, 0);  // R5 R8 write half both
    run(2'd2, 0, 1, 0, 3, 1, 0);  // R6 R8 write half alone
    run(2'd2, 0, 3, 0, 0, 0, 0);  // R8 read half error ends cycle
    run(2'd0, 5, 0, 0, 0, 0, 0);  // R9 watchdog limit 5
    run(2'd0, 1, 0, 0, 0, 0, 0);  // R9 watchdog limit 1
    run(2'd2, 10, 1, 0, 0, 0, 0); // R9 restart at state 8
    run(2'd0, 0, 1, 1, 0, 0, 1);  // R10 start while busy
    run(2'd3, 0, 1, 0, 0, 0, 0);  // R8 kind 3 is write
    repeat (30) @(negedge clk);
    check("R10 queue drained", q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule